// File: doc/BRIEF.md
# Coprocessor Bus Control Register

This block sits on the host CPU's I/O bus and gives the host control over a second processor that shares an external RAM module with it. A single byte-wide register is decoded over a small window of aliased addresses. Writes drive the coprocessor's reset, interrupt and bus-request lines and a RAM-ownership bit. Reads return the control bits together with the coprocessor's bus-acknowledge and one of its data lines.

The host takes the shared RAM through a handshake. It asserts bus request, and the coprocessor pauses and floats its bus. The coprocessor then answers with a low acknowledge. Both coprocessor inputs are asynchronous to the host clock, so each passes through a two-flop synchroniser. The block raises a grant output only while its own request is asserted and the synchronised acknowledge is low. The RAM-ownership bit drives the module's active-low select, which detaches the RAM from the expansion bus.

Top module: `cbc_copro_ctrl`

## Requirements
- R1: With the default parameters, every address from 0xD1F0 to 0xD1F7 reaches the same register. A write in any of them takes effect on the outputs after the clock edge that samples it.
- R2: Written bit 0 drives `cop_rst_n` directly. A 0 holds the coprocessor in reset.
- R3: Written bit 1 drives `cop_irq_n` directly. A 0 requests an interrupt.
- R4: Written bit 2 drives `cop_busrq_n` directly. A 0 requests the coprocessor's bus.
- R5: Written bit 3 is active high. When it is 1, `ram_sel_n` is driven 0. When it is 0, `ram_sel_n` is 1.
- R6: Read data has the following layout. Bit 7 is the synchronised `cop_d7`. Bit 6 is the synchronised `cop_busack_n`. Bits 5:4 are always 0, whatever was written to them. Bits 3:0 hold the control bits in the order ram-own, bus-request, interrupt, reset, from bit 3 down to bit 0.
- R7: A change on `cop_busack_n` or `cop_d7` does not appear on the read path one clock edge after it. It appears after the second clock edge.
- R8: After reset the outputs are `cop_rst_n`=0, `cop_irq_n`=1, `cop_busrq_n`=1 and `ram_sel_n`=1. With `cop_busack_n` held high and `cop_d7` held low, a read returns 0x46.
- R9: Writes to addresses outside the window leave all outputs unchanged. Reads outside the window return 0x00.
- R10: `host_ram_grant` is 1 exactly when `cop_busrq_n` is 0 and the synchronised acknowledge is 0. It falls in the cycle after a write that releases the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| bus_addr | input | 16 | Host address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; 0 when no read hits the window |
| cop_rst_n | output | 1 | Coprocessor reset, active low |
| cop_irq_n | output | 1 | Coprocessor interrupt, active low |
| cop_busrq_n | output | 1 | Coprocessor bus request, active low |
| cop_busack_n | input | 1 | Coprocessor bus acknowledge, active low, asynchronous |
| cop_d7 | input | 1 | Coprocessor data line 7, asynchronous |
| ram_sel_n | output | 1 | Shared RAM module select, active low |
| host_ram_grant | output | 1 | The host may drive the shared RAM |

## Verification
A host write that releases bus request can land in the same cycle as a change in the coprocessor's acknowledge. The grant must follow the register in that case and ignore the acknowledge still in the synchroniser. The bench provokes this by writing 0x07 on the same edge at which `cop_busack_n` rises. It expects the grant to be 0 right after that edge and to stay 0 when the request is asserted again before the new acknowledge has settled. The opposite case is also covered: the acknowledge falls while the request is asserted, and the grant must rise only after the second edge.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int DATA_W   = 8;
  localparam int CTRL_W   = 4;
  localparam int SYNC_W   = 2;
  localparam int BIT_ACK  = 6;
  localparam int BIT_D7   = 7;

  typedef struct packed {
    logic ram_own;
    logic busrq_n;
    logic irq_n;
    logic rst_n;
  } cbc_ctrl_t;

  localparam cbc_ctrl_t CTRL_RST = '{ram_own: 1'b0, busrq_n: 1'b1, irq_n: 1'b1, rst_n: 1'b0};
  localparam logic [SYNC_W-1:0] SYNC_RST = 2'b01;
endpackage

// File: rtl/cbc_rst_sync.sv
module cbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/cbc_decode.sv
module cbc_decode #(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] BASE    = 16'hD1F0,
  parameter int                ALIAS_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int              TAG_W = ADDR_W - ALIAS_W;
  localparam logic [TAG_W-1:0] TAG  = BASE[ADDR_W-1:ALIAS_W];

  always_comb hit = (addr[ADDR_W-1:ALIAS_W] == TAG);
endmodule

// File: rtl/cbc_sync.sv
module cbc_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= RST_VAL;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cbc_ctrl_reg.sv
module cbc_ctrl_reg
  import cbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output cbc_ctrl_t         ctrl
);
  cbc_ctrl_t ctrl_d;
  cbc_ctrl_t ctrl_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = cbc_ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= CTRL_RST;
    else if (wr_en) ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/cbc_copro_ctrl.sv
module cbc_copro_ctrl
  import cbc_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE        = 16'hD1F0,
  parameter int                ALIAS_W     = 3,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cop_rst_n,
  output logic              cop_irq_n,
  output logic              cop_busrq_n,
  input  logic              cop_busack_n,
  input  logic              cop_d7,
  output logic              ram_sel_n,
  output logic              host_ram_grant
);
  logic              rst_q;
  logic              hit;
  logic              wr_en;
  cbc_ctrl_t         ctrl;
  logic [SYNC_W-1:0] sync_q;
  logic              ack_s_n;
  logic              d7_s;

  cbc_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  cbc_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .ALIAS_W(ALIAS_W)) u_dec (
    .addr(bus_addr), .hit(hit)
  );

  always_comb wr_en = bus_wr & hit;

  cbc_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wdata(bus_wdata), .ctrl(ctrl)
  );

  cbc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_q), .d({cop_d7, cop_busack_n}), .q(sync_q)
  );

  assign ack_s_n = sync_q[0];
  assign d7_s    = sync_q[1];

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && hit) begin
      bus_rdata[CTRL_W-1:0] = ctrl;
      bus_rdata[BIT_ACK]    = ack_s_n;
      bus_rdata[BIT_D7]     = d7_s;
    end
  end

  assign cop_rst_n      = ctrl.rst_n;
  assign cop_irq_n      = ctrl.irq_n;
  assign cop_busrq_n    = ctrl.busrq_n;
  assign ram_sel_n      = ~ctrl.ram_own;
  assign host_ram_grant = ~ctrl.busrq_n & ~ack_s_n;
endmodule

// File: rtl/cbc_copro_ctrl_chk.sv
module cbc_copro_ctrl_chk #(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] BASE    = 16'hD1F0,
  parameter int                ALIAS_W = 3
) (
  input logic              clk,
  input logic              rst_q,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              cop_rst_n,
  input logic              cop_irq_n,
  input logic              cop_busrq_n,
  input logic              cop_busack_n,
  input logic              cop_d7,
  input logic              ram_sel_n,
  input logic              host_ram_grant
);
  logic       in_win;
  logic [1:0] age_q;
  logic       ready;

  assign in_win = (bus_addr[ADDR_W-1:ALIAS_W] == BASE[ADDR_W-1:ALIAS_W]);

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  assign ready = (age_q == 2'd3);

  assert_reset_state_R8: assert property (@(posedge clk)
    $rose(rst_q) |-> (!cop_rst_n && cop_irq_n && cop_busrq_n && ram_sel_n));

  // R2 R3 R4 R5: every control line follows its written bit
  assert_alias_write_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_wr && in_win) |=> (cop_rst_n == $past(bus_wdata[0]) && cop_irq_n == $past(bus_wdata[1])
      && cop_busrq_n == $past(bus_wdata[2]) && ram_sel_n == !$past(bus_wdata[3])));

  assert_no_stray_write_R9: assert property (@(posedge clk) disable iff (!rst_q)
    !(bus_wr && in_win) |=> $stable({cop_rst_n, cop_irq_n, cop_busrq_n, ram_sel_n}));

  assert_read_layout_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_rd && in_win) |-> (bus_rdata[5:4] == 2'b00
      && bus_rdata[3:0] == {!ram_sel_n, cop_busrq_n, cop_irq_n, cop_rst_n}));

  assert_read_outside_R9: assert property (@(posedge clk) disable iff (!rst_q)
    !(bus_rd && in_win) |-> (bus_rdata == 8'h00));

  assert_sync_delay_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (ready && bus_rd && in_win) |-> (bus_rdata[7] == $past(cop_d7, 2)
      && bus_rdata[6] == $past(cop_busack_n, 2)));

  assert_grant_R10: assert property (@(posedge clk) disable iff (!rst_q)
    ready |-> (host_ram_grant == (!cop_busrq_n && !$past(cop_busack_n, 2))));

  assert_grant_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_q)
    host_ram_grant |-> !cop_busrq_n);
endmodule

bind cbc_copro_ctrl cbc_copro_ctrl_chk #(.ADDR_W(ADDR_W), .BASE(BASE), .ALIAS_W(ALIAS_W)) chk_i (.*);

// File: tb/cbc_copro_ctrl_tb.sv
module cbc_copro_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        cop_rst_n, cop_irq_n, cop_busrq_n;
  logic        cop_busack_n, cop_d7;
  logic        ram_sel_n, host_ram_grant;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbc_copro_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cop_rst_n(cop_rst_n),
    .cop_irq_n(cop_irq_n), .cop_busrq_n(cop_busrq_n), .cop_busack_n(cop_busack_n),
    .cop_d7(cop_d7), .ram_sel_n(ram_sel_n), .host_ram_grant(host_ram_grant)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {4'h0, ram_sel_n, cop_busrq_n, cop_irq_n, cop_rst_n};
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    check("R8 outputs", outs(), 8'h0E);
    rd(16'hD1F0, r);
    check("R8 readback", r, 8'h46);
  endtask

  task automatic t_alias();
    logic [7:0] r;
    for (int a = 0; a < 8; a++) begin
      logic [7:0] d = 8'(a * 2 + 1) ^ 8'h0A;
      wr(16'hD1F0 + 16'(a), d);
      // R2 R3 R4 R5: output lines follow written bits, ram select inverted
      check("R1 write alias", outs(), {4'h0, ~d[3], d[2], d[1], d[0]});
      rd(16'hD1F7 - 16'(a), r);
      check("R6 readback bits 3:0", r, {8'h40 | {4'h0, d[3:0]}});
    end
  endtask

  task automatic t_rsvd();
    logic [7:0] r;
    wr(16'hD1F3, 8'hFF);
    check("R5 ram select low", {7'h0, ram_sel_n}, 8'h00);
    rd(16'hD1F5, r);
    check("R6 bits 5:4 read 0", r, 8'h4F);
    wr(16'hD1F2, 8'hF7);
    check("R5 ram select high", {7'h0, ram_sel_n}, 8'h01);
    wr(16'hD1F1, 8'h3F);
    rd(16'hD1F0, r);
    check("R6 bits 5:4 ignored", r, 8'h4F);
  endtask

  task automatic t_outside();
    logic [7:0] r;
    wr(16'hD1EF, 8'h00);
    check("R9 below window", outs(), 8'h07);
    wr(16'hD1F8, 8'h00);
    check("R9 above window", outs(), 8'h07);
    wr(16'hE1F0, 8'h00);
    check("R9 high address bits", outs(), 8'h07);
    rd(16'hD1F8, r);
    check("R9 read outside", r, 8'h00);
  endtask

  task automatic t_sync();
    logic [7:0] r;
    cop_busack_n = 1'b0; cop_d7 = 1'b1;
    rd(16'hD1F4, r);
    check("R7 same cycle", r, 8'h4F);
    @(negedge clk);
    rd(16'hD1F4, r);
    check("R7 after one edge", r, 8'h4F);
    @(negedge clk);
    rd(16'hD1F4, r);
    check("R7 after two edges", r, 8'h8F);
  endtask

  task automatic t_grant();
    check("R10 no request", {7'h0, host_ram_grant}, 8'h00);
    wr(16'hD1F0, 8'h03);
    check("R4 request asserted", {7'h0, cop_busrq_n}, 8'h00);
    check("R10 grant rises", {7'h0, host_ram_grant}, 8'h01);
    // ack rises while request held: grant lingers until sync passes it
    cop_busack_n = 1'b1;
    @(negedge clk);
    check("R10 grant held one edge", {7'h0, host_ram_grant}, 8'h01);
    @(negedge clk);
    check("R10 grant drops after sync", {7'h0, host_ram_grant}, 8'h00);
    cop_busack_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R10 grant back", {7'h0, host_ram_grant}, 8'h01);
    // release request in the same cycle the acknowledge rises
    cop_busack_n = 1'b1;
    wr(16'hD1F6, 8'h07);
    check("R10 grant drops on release", {7'h0, host_ram_grant}, 8'h00);
    wr(16'hD1F6, 8'h03);
    check("R10 stale ack ignored", {7'h0, host_ram_grant}, 8'h00);
    cop_busack_n = 1'b0;
    @(negedge clk);
    check("R10 new ack one edge", {7'h0, host_ram_grant}, 8'h00);
    @(negedge clk);
    check("R10 new ack two edges", {7'h0, host_ram_grant}, 8'h01);
    wr(16'hD1F0, 8'h05);
    check("R3 interrupt low", {7'h0, cop_irq_n}, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    cop_busack_n = 1'b1; cop_d7 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_alias();
    t_rsvd();
    t_outside();
    t_sync();
    t_grant();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule